// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and carries out one block erase per request. A requester presents a block number with a valid/ready handshake. The sequencer then runs the erase sequence on the flash bus. It sends the erase-setup command and the row address bytes, with the page field inside each row cleared to zero. It then sends the erase-go command, which starts the erase inside the flash.

While the flash is busy, only legal traffic goes on the bus. The sequencer writes a status-read command and reads back one status byte, and it repeats this until the ready bit is set. It then pulses a done strobe with a pass flag taken from the fail bit. A programmable clock-cycle limit guards the wait. If the limit runs out before the flash reports ready, the sequencer issues a reset command and reports a failure.

A parameter sets the number of row address bytes to two or three, so that one design covers small and large device densities. Each bus cycle takes two clocks: a strobe-low phase followed by a strobe-high phase. A write byte is latched by the flash on the rising edge of its write strobe. A read byte is captured by the sequencer just before the read strobe rises.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, reqReady is 1, doneValid is 0, both strobes nandWeN and nandReN are 1, nandCle and nandAle are 0 and nandIoOe is 0.
- R2: An accepted request (reqValid and reqReady both high at a clock edge) first produces a write cycle with nandCle=1, nandAle=0 and byte 0x60 on nandIoOut.
- R3: Next come exactly ROW_CYCLES write cycles with nandAle=1 and nandCle=0. They carry the row value reqBlock shifted left by PAGE_BITS (6), least significant byte first, so the 6 page bits are always zero.
- R4: After the last row byte, a command write cycle carries 0xD0.
- R5: After 0xD0, the sequencer loops a command cycle of 0x70 followed by one read cycle (nandReN low). It stops after the first read whose bit 6 is 1.
- R6: When that read shows bit 6 set, doneValid is high for exactly one clock, and donePass equals the inverse of bit 0 of that status byte.
- R7: If timeoutLimit clocks have passed in the poll loop and a read still shows bit 6 clear, the sequencer writes command 0xFF, then pulses doneValid with donePass=0.
- R8: reqReady is 0 from the clock after acceptance through the doneValid cycle, and returns to 1 on the next clock. Requests presented during that time start no new sequence.
- R9: Between 0xD0 and the done pulse, the only bus traffic is command 0x70, command 0xFF and status reads. The sequencer never drives the data bus while nandReN is low.
- R10: nandCle and nandAle are never high together, and nandWeN and nandReN are never low together.
- R11: With ROW_CYCLES=2, exactly two row bytes are sent, again least significant byte first, with the page bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Erase request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqBlock | input | BLOCK_W | Block number to erase |
| timeoutLimit | input | TMO_W | Clock limit on the status wait |
| doneValid | output | 1 | One-clock completion strobe |
| donePass | output | 1 | Erase result, valid with doneValid |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Byte driven onto the flash data bus |
| nandIoOe | output | 1 | Output enable for nandIoOut |
| nandIoIn | input | 8 | Byte returned by the flash |

## Verification
A wrong controller state shows up on the bus within one bus cycle, about four clocks. It appears as a command byte out of order, an extra or missing row byte, or a command other than status-read or reset while the flash is busy. A fault in the row register or the byte index corrupts the page-zero bits or the byte order of the very next address cycle. A fault in status capture shows in the number of reads before done, or in the pass flag of the next done pulse. A stuck timer shows up as a reset command that never comes or comes too early. The bench compares the full logged bus sequence of each erase against one computed from the block number, the poll count and the fail flag.

// File: rtl/nand_erase_pkg.sv
`timescale 1ns/1ps
package nand_erase_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_CMD,
    OP_ADDR,
    OP_READ
  } busOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadRow;
    logic   start;
    busOp_e op;
    logic [7:0] cmd;
    logic   clrTimer;
    logic   runTimer;
  } ctrlStrobe_t;

  // feedback from datapath to control
  typedef struct packed {
    logic cycleDone;
    logic engIdle;
    logic lastAddr;
    logic flashReady;
    logic flashFail;
    logic timedOut;
  } dpStatus_t;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam int STAT_READY_BIT = 6;
  localparam int STAT_FAIL_BIT  = 0;

endpackage

// File: rtl/erase_dp.sv
`timescale 1ns/1ps
module erase_dp
  import nand_erase_pkg::*;
#(
  parameter int BLOCK_W    = 12,
  parameter int ROW_CYCLES = 3,
  parameter int PAGE_BITS  = 6,
  parameter int TMO_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [TMO_W-1:0]   timeoutLimit,
  input  logic [7:0]         ioIn,
  output dpStatus_t          status,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic [7:0]         ioOut,
  output logic               ioOe
);

  localparam int ROW_W    = 8 * ROW_CYCLES;
  localparam int BLK_USED = (BLOCK_W < ROW_W - PAGE_BITS) ? BLOCK_W : (ROW_W - PAGE_BITS);
  localparam int IDX_W    = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;
  localparam logic [7:0] PAGE_MASK = (PAGE_BITS >= 8) ? 8'hFF : 8'((1 << PAGE_BITS) - 1);

  logic [ROW_W-1:0] rowAddr, rowNext;
  logic [IDX_W-1:0] addrIdx;
  logic [7:0]       addrByte;
  logic             active, phase, cycleDone;
  busOp_e           curOp;
  logic             readyQ, failQ;
  logic [TMO_W-1:0] timer;

  // row value: block above the page field, page field zero
  always_comb begin
    rowNext = '0;
    rowNext[PAGE_BITS +: BLK_USED] = reqBlock[BLK_USED-1:0];
  end

  assign addrByte = 8'(rowAddr >> {addrIdx, 3'b000});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr <= '0;
      addrIdx <= '0;
    end else if (strobe.loadRow) begin
      rowAddr <= rowNext;
      addrIdx <= '0;
    end else if (cycleDone && curOp == OP_ADDR) begin
      addrIdx <= addrIdx + 1'b1;
    end
  end

  // two-clock bus cycle engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phase     <= 1'b0;
      cycleDone <= 1'b0;
      curOp     <= OP_NONE;
      cle       <= 1'b0;
      ale       <= 1'b0;
      weN       <= 1'b1;
      reN       <= 1'b1;
      ioOut     <= 8'h00;
      ioOe      <= 1'b0;
    end else begin
      cycleDone <= 1'b0;
      if (!active) begin
        if (strobe.start) begin
          active <= 1'b1;
          phase  <= 1'b0;
          curOp  <= strobe.op;
          cle    <= (strobe.op == OP_CMD);
          ale    <= (strobe.op == OP_ADDR);
          weN    <= !(strobe.op == OP_CMD || strobe.op == OP_ADDR);
          reN    <= !(strobe.op == OP_READ);
          ioOe   <= (strobe.op == OP_CMD || strobe.op == OP_ADDR);
          ioOut  <= (strobe.op == OP_ADDR) ? addrByte : strobe.cmd;
        end
      end else if (!phase) begin
        phase <= 1'b1;
        weN   <= 1'b1;
        reN   <= 1'b1;
      end else begin
        active    <= 1'b0;
        phase     <= 1'b0;
        cle       <= 1'b0;
        ale       <= 1'b0;
        ioOe      <= 1'b0;
        cycleDone <= 1'b1;
      end
    end
  end

  // status byte capture at the end of the read-low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      failQ  <= 1'b0;
    end else if (active && !phase && curOp == OP_READ) begin
      readyQ <= ioIn[STAT_READY_BIT];
      failQ  <= ioIn[STAT_FAIL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   timer <= '0;
    else if (strobe.clrTimer)                    timer <= '0;
    else if (strobe.runTimer && timer != '1)     timer <= timer + 1'b1;
  end

  always_comb begin
    status.cycleDone  = cycleDone;
    status.engIdle    = !active;
    status.lastAddr   = (addrIdx == IDX_W'(ROW_CYCLES - 1));
    status.flashReady = readyQ;
    status.flashFail  = failQ;
    status.timedOut   = (timer >= timeoutLimit);
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale) && !(!weN && !reN));

  p_page_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ale && !weN && addrIdx == '0) |-> ((ioOut & PAGE_MASK) == 8'h00));

  p_no_drive_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !ioOe);

endmodule

// File: rtl/erase_ctrl.sv
`timescale 1ns/1ps
module erase_ctrl
  import nand_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   dpStat,
  output logic        reqReady,
  output logic        doneValid,
  output logic        donePass,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONF, S_POLLCMD, S_POLLREAD, S_ABORT, S_DONE
  } state_e;

  state_e state, stateNext;
  logic   launch;

  assign launch = dpStat.engIdle && !dpStat.cycleDone;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strobe.loadRow = 1'b1;
        stateNext      = S_SETUP;
      end
      S_SETUP: begin
        strobe.op    = OP_CMD;
        strobe.cmd   = CMD_ERASE_SETUP;
        strobe.start = launch;
        if (dpStat.cycleDone) stateNext = S_ADDR;
      end
      S_ADDR: begin
        strobe.op    = OP_ADDR;
        strobe.start = launch;
        if (dpStat.cycleDone && dpStat.lastAddr) stateNext = S_CONF;
      end
      S_CONF: begin
        strobe.op    = OP_CMD;
        strobe.cmd   = CMD_ERASE_GO;
        strobe.start = launch;
        if (dpStat.cycleDone) begin
          strobe.clrTimer = 1'b1;
          stateNext       = S_POLLCMD;
        end
      end
      S_POLLCMD: begin
        strobe.runTimer = 1'b1;
        strobe.op       = OP_CMD;
        strobe.cmd      = CMD_STATUS;
        strobe.start    = launch;
        if (dpStat.cycleDone) stateNext = S_POLLREAD;
      end
      S_POLLREAD: begin
        strobe.runTimer = 1'b1;
        strobe.op       = OP_READ;
        strobe.start    = launch;
        if (dpStat.cycleDone) begin
          if (dpStat.flashReady)    stateNext = S_DONE;
          else if (dpStat.timedOut) stateNext = S_ABORT;
          else                      stateNext = S_POLLCMD;
        end
      end
      S_ABORT: begin
        strobe.op    = OP_CMD;
        strobe.cmd   = CMD_RESET;
        strobe.start = launch;
        if (dpStat.cycleDone) stateNext = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      donePass <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_POLLREAD && dpStat.cycleDone && dpStat.flashReady)
        donePass <= !dpStat.flashFail;
      else if (state == S_ABORT)
        donePass <= 1'b0;
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_pass_needs_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && donePass) |-> (dpStat.flashReady && !dpStat.flashFail));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_busy_cmds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && strobe.op == OP_CMD &&
     (state == S_POLLCMD || state == S_POLLREAD || state == S_ABORT))
    |-> (strobe.cmd == CMD_STATUS || strobe.cmd == CMD_RESET));

endmodule

// File: rtl/nand_erase_seq.sv
`timescale 1ns/1ps
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLOCK_W    = 12,
  parameter int ROW_CYCLES = 3,
  parameter int PAGE_BITS  = 6,
  parameter int TMO_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [TMO_W-1:0]   timeoutLimit,
  output logic               doneValid,
  output logic               donePass,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic               nandReN,
  output logic [7:0]         nandIoOut,
  output logic               nandIoOe,
  input  logic [7:0]         nandIoIn
);

  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;

  erase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .dpStat    (dpStat),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .donePass  (donePass),
    .strobe    (strobe)
  );

  erase_dp #(
    .BLOCK_W    (BLOCK_W),
    .ROW_CYCLES (ROW_CYCLES),
    .PAGE_BITS  (PAGE_BITS),
    .TMO_W      (TMO_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqBlock     (reqBlock),
    .timeoutLimit (timeoutLimit),
    .ioIn         (nandIoIn),
    .status       (dpStat),
    .cle          (nandCle),
    .ale          (nandAle),
    .weN          (nandWeN),
    .reN          (nandReN),
    .ioOut        (nandIoOut),
    .ioOe         (nandIoOe)
  );

endmodule

// File: tb/tb_nand_erase_seq.sv
`timescale 1ns/1ps
module tb_nand_model (
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic [7:0] ioOut,
  input  int         busyPolls,
  input  logic       failBit,
  output logic [7:0] ioIn
);
  logic [9:0] logEnt [64];
  int  logCnt  = 0;
  int  readCnt = 0;
  bit  erasing = 0;
  logic rdy;

  always @(posedge weN) begin
    if (cle && ioOut == 8'h60) logCnt = 0;
    if (logCnt < 64) logEnt[logCnt] = {cle, ale, ioOut};
    logCnt++;
    if (cle && ioOut == 8'hD0) begin erasing = 1; readCnt = 0; end
    if (cle && ioOut == 8'hFF) erasing = 0;
  end

  always @(posedge reN) readCnt++;

  assign rdy  = !erasing || (readCnt >= busyPolls);
  assign ioIn = reN ? 8'h00 : {1'b0, rdy, 5'b00000, rdy & failBit};
endmodule

module tb_nand_erase_seq;
  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;

  int   busyPolls = 0;
  logic failBit = 0;
  logic [15:0] tmoLim = 16'hFFFF;
  int totalCnt = 0, failCnt = 0, cycles = 0;

  logic rv3 = 0, rdy3, dv3, dp3, cle3, ale3, we3, re3, oe3;
  logic [11:0] blk3 = 0;
  logic [7:0] out3, in3;
  logic rv2 = 0, rdy2, dv2, dp2, cle2, ale2, we2, re2, oe2;
  logic [9:0] blk2 = 0;
  logic [7:0] out2, in2;

  nand_erase_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(rv3), .reqReady(rdy3), .reqBlock(blk3),
    .timeoutLimit(tmoLim), .doneValid(dv3), .donePass(dp3), .nandCle(cle3),
    .nandAle(ale3), .nandWeN(we3), .nandReN(re3), .nandIoOut(out3),
    .nandIoOe(oe3), .nandIoIn(in3));

  nand_erase_seq #(.BLOCK_W(10), .ROW_CYCLES(2)) dut2 (
    .clk(clk), .rstN(rstN), .reqValid(rv2), .reqReady(rdy2), .reqBlock(blk2),
    .timeoutLimit(tmoLim), .doneValid(dv2), .donePass(dp2), .nandCle(cle2),
    .nandAle(ale2), .nandWeN(we2), .nandReN(re2), .nandIoOut(out2),
    .nandIoOe(oe2), .nandIoIn(in2));

  tb_nand_model m3 (.cle(cle3), .ale(ale3), .weN(we3), .reN(re3), .ioOut(out3),
    .busyPolls(busyPolls), .failBit(failBit), .ioIn(in3));
  tb_nand_model m2 (.cle(cle2), .ale(ale2), .weN(we2), .reN(re2), .ioOut(out2),
    .busyPolls(busyPolls), .failBit(failBit), .ioIn(in2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] entAt(input bit use2, input int i);
    if (i < 0 || i > 63) return 10'h3FF;
    return use2 ? m2.logEnt[i] : m3.logEnt[i];
  endfunction

  function automatic logic [7:0] rowByte(input bit use2, input logic [11:0] blk, input int k);
    logic [23:0] r;
    r = use2 ? (24'(blk[9:0]) << 6) : (24'(blk) << 6);
    return r[8*k +: 8];
  endfunction

  function automatic logic curReady(input bit use2);
    return use2 ? rdy2 : rdy3;
  endfunction
  function automatic logic curDone(input bit use2);
    return use2 ? dv2 : dv3;
  endfunction
  function automatic logic curPass(input bit use2);
    return use2 ? dp2 : dp3;
  endfunction

  task automatic setReq(input bit use2, input logic v, input logic [11:0] blk);
    if (use2) begin rv2 = v; blk2 = blk[9:0]; end
    else      begin rv3 = v; blk3 = blk; end
  endtask

  task automatic runErase(input bit use2, input logic [11:0] blk, input int polls,
                          input bit fl, input logic [15:0] tmo, input bit expTmo,
                          input bit pester);
    int rc, lc, rd, base;
    bit seen;
    rc = use2 ? 2 : 3;
    busyPolls = polls; failBit = fl; tmoLim = tmo;
    @(negedge clk);
    setReq(use2, 1'b1, blk);
    @(negedge clk);
    if (pester) setReq(use2, 1'b1, ~blk);
    else        setReq(use2, 1'b0, blk);
    chk("R8 ready low after accept", 32'(curReady(use2)), 32'h0);
    seen = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (curDone(use2)) begin seen = 1; break; end
    end
    chk("R6 done seen", 32'(seen), 32'h1);
    chk(expTmo ? "R7 timeout fail" : "R6 pass flag", 32'(curPass(use2)),
        expTmo ? 32'h0 : 32'(!fl));
    chk("R8 ready low in done cycle", 32'(curReady(use2)), 32'h0);
    setReq(use2, 1'b0, blk);
    @(negedge clk);
    chk("R6 done single pulse", 32'(curDone(use2)), 32'h0);
    chk("R8 ready back", 32'(curReady(use2)), 32'h1);
    lc = use2 ? m2.logCnt : m3.logCnt;
    rd = use2 ? m2.readCnt : m3.readCnt;
    chk("R2 setup cmd", 32'(entAt(use2, 0)), {22'h0, 2'b10, 8'h60});
    for (int k = 0; k < rc; k++)
      chk(use2 ? "R11 row byte" : "R3 row byte", 32'(entAt(use2, 1 + k)),
          {22'h0, 2'b01, rowByte(use2, blk, k)});
    chk("R4 confirm cmd", 32'(entAt(use2, rc + 1)), {22'h0, 2'b10, 8'hD0});
    base = rc + 2;
    if (!expTmo) begin
      chk("R5 status cmd count", 32'(lc - base), 32'(polls + 1));
      chk("R5 read count", 32'(rd), 32'(polls + 1));
      for (int i = base; i < lc && i < 64; i++)
        chk("R9 busy only status", 32'(entAt(use2, i)), {22'h0, 2'b10, 8'h70});
    end else begin
      chk("R7 reset cmd last", 32'(entAt(use2, lc - 1)), {22'h0, 2'b10, 8'hFF});
      chk("R7 reads match polls", 32'(lc - base - 1), 32'(rd));
      chk("R7 polled at least once", 32'(rd >= 1), 32'h1);
      for (int i = base; i < lc - 1 && i < 64; i++)
        chk("R9 busy only status", 32'(entAt(use2, i)), {22'h0, 2'b10, 8'h70});
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      if ((cle3 && ale3) || (!we3 && !re3))
        chk("R10 strobe exclusion dut", 32'h1, 32'h0);
      if ((cle2 && ale2) || (!we2 && !re2))
        chk("R10 strobe exclusion dut2", 32'h1, 32'h0);
      if ((!re3 && oe3) || (!re2 && oe2))
        chk("R9 drive during read", 32'h1, 32'h0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(rdy3), 32'h1);
    chk("R1 done low", 32'(dv3), 32'h0);
    chk("R1 strobes idle", {28'h0, we3, re3, cle3, ale3}, 32'hC);
    chk("R1 no drive", 32'(oe3), 32'h0);
    chk("R1 dut2 idle", {27'h0, rdy2, we2, re2, cle2, ale2}, 32'h1C);

    runErase(0, 12'h000, 0, 0, 16'hFFFF, 0, 0);
    runErase(0, 12'hFFF, 3, 1, 16'hFFFF, 0, 0);
    runErase(0, 12'hA5C, 2, 0, 16'hFFFF, 0, 1);
    runErase(1, 12'h3FF, 1, 0, 16'hFFFF, 0, 0);
    runErase(1, 12'h155, 0, 1, 16'hFFFF, 0, 1);
    runErase(0, 12'h123, 1000, 0, 16'd40, 1, 0);
    runErase(1, 12'h2AA, 1000, 1, 16'd20, 1, 1);

    for (int t = 0; t < 24; t++) begin
      bit u2 = bit'($urandom % 2);
      runErase(u2, 12'($urandom), int'($urandom % 6), bit'($urandom % 2),
               16'hFFFF, 0, bit'($urandom % 2));
    end

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule